// File: doc/BRIEF.md
# Two-Phase Sliced Word Adder

This block adds two 10-bit words with carry hardware only 5 bits wide. Each operand reaches the block as two 5-bit slices on consecutive cycles of a fast clock. A phase input that toggles at half the fast-clock rate says which half is on the bus: the less significant half while it is low, the more significant half while it is high. The carry out of the low half is held in a flip-flop and fed into the high half on the next cycle. Time-sharing one narrow adder across the two halves of a word roughly halves the logic and routing a full-width adder would need. Each slice still finishes in one fast-clock period.

The sum leaves the block in the same sliced form. It comes with a registered phase flag and an overflow flag that marks the high output slice when the full 10-bit sum does not fit. The output slices keep the input order and are one cycle late. An output can therefore feed the operand input of another copy of the block, so adder trees can be built without reformatting. Words may follow one another with no gap. The carry never reaches from one word into the next.

Top module: `sliced_word_adder`

## Requirements
- R1: While `rst` is high at a rising edge, the block clears `sum_slice`, `out_phase` and `ovf` to 0 on that edge.
- R2: A low slice (`in_phase` = 0) sampled at an edge produces `sum_slice` = (`a_slice` + `b_slice`) mod 32 after that edge. Bits 4:0 of the word are the low slice.
- R3: A high slice (`in_phase` = 1) sampled at an edge produces `sum_slice` = (`a_slice` + `b_slice` + carry) mod 32 after that edge. The carry is the carry out of the low slice of the same word, sampled on the edge before. Bits 9:5 of the word are the high slice.
- R4: `ovf` is 1 after a high slice exactly when the 10-bit operands sum to 1024 or more. `ovf` is always 0 while `out_phase` is 0.
- R5: A low slice always adds with a carry in of 0. A carry left over from the previous word's high slice has no effect on the next word.
- R6: `out_phase` equals the `in_phase` value sampled on the preceding edge. Each output slice is tagged with the phase of the input slice it came from.
- R7: Words may arrive back to back on every cycle with no idle gap. Each slice appears at the output exactly one cycle after it was sampled, so one word completes every two cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock; one slice per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_phase | input | 1 | Slice selector: 0 = low half, 1 = high half |
| a_slice | input | 5 | Current slice of operand A |
| b_slice | input | 5 | Current slice of operand B |
| sum_slice | output | 5 | Registered slice of the sum |
| out_phase | output | 1 | Registered phase tag for `sum_slice` |
| ovf | output | 1 | Overflow of the full word, valid with the high output slice |

## Verification
Two things can fall in the same cycle: the carry register still holds a 1 from an overflowing high slice, and the first low slice of the next word is being added. The bench provokes this by sending a word whose sum overflows, such as 1023 + 1, and following it at once with small operands whose low halves must not pick up that carry. The result is judged at the ports: the low output slice of the second word must equal the plain 5-bit sum of its low halves, and `ovf` must stay 0 with it.

// File: rtl/sliced_add_pkg.sv
package sliced_add_pkg;

    localparam int SLICE_W = 5;
    localparam int SLICES  = 2;
    localparam int WORD_W  = SLICE_W * SLICES;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    typedef struct packed {
        logic               cout;
        logic [SLICE_W-1:0] sum;
    } slice_res_t;

    function automatic slice_res_t slice_add(
        input logic [SLICE_W-1:0] a,
        input logic [SLICE_W-1:0] b,
        input logic               cin
    );
        logic [SLICE_W:0] t;
        t = {1'b0, a} + {1'b0, b} + {{SLICE_W{1'b0}}, cin};
        return slice_res_t'(t);
    endfunction

endpackage

// File: rtl/slice_alu.sv
module slice_alu
    import sliced_add_pkg::*;
(
    input  logic [SLICE_W-1:0] op_a,
    input  logic [SLICE_W-1:0] op_b,
    input  logic               cin,
    output slice_res_t         res
);
    always_comb begin
        res = slice_add(op_a, op_b, cin);
    end
endmodule

// File: rtl/carry_keeper.sv
module carry_keeper
    import sliced_add_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_e phase,
    input  logic   cout_now,
    output logic   cin_now
);
    logic carry_q;

    always_ff @(posedge clk) begin
        if (rst) carry_q <= 1'b0;
        else     carry_q <= cout_now;
    end

    // A low slice starts a new word: the held carry is masked out.
    always_comb begin
        cin_now = (phase == PH_HIGH) ? carry_q : 1'b0;
    end

    // R5: the carry fed to a low slice is zero even after an overflowing word
    assert_low_cin_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LOW) |-> (cin_now == 1'b0));
endmodule

// File: rtl/slice_out_stage.sv
module slice_out_stage
    import sliced_add_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  phase_e             phase,
    input  slice_res_t         res,
    output logic [SLICE_W-1:0] sum_q,
    output phase_e             phase_q,
    output logic               ovf_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q   <= '0;
            phase_q <= PH_LOW;
            ovf_q   <= 1'b0;
        end else begin
            sum_q   <= res.sum;
            phase_q <= phase;
            ovf_q   <= (phase == PH_HIGH) && res.cout;
        end
    end

    // R4: overflow only ever accompanies a high output slice
    assert_ovf_high_only_R4: assert property (@(posedge clk) disable iff (rst)
        ovf_q |-> (phase_q == PH_HIGH));
endmodule

// File: rtl/sliced_word_adder.sv
module sliced_word_adder
    import sliced_add_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_phase,
    input  logic [SLICE_W-1:0] a_slice,
    input  logic [SLICE_W-1:0] b_slice,
    output logic [SLICE_W-1:0] sum_slice,
    output logic               out_phase,
    output logic               ovf
);
    phase_e     ph_in;
    phase_e     ph_out;
    logic       carry_in;
    slice_res_t alu_res;

    assign ph_in     = phase_e'(in_phase);
    assign out_phase = (ph_out == PH_HIGH);

    slice_alu u_alu (
        .op_a (a_slice),
        .op_b (b_slice),
        .cin  (carry_in),
        .res  (alu_res)
    );

    carry_keeper u_carry (
        .clk      (clk),
        .rst      (rst),
        .phase    (ph_in),
        .cout_now (alu_res.cout),
        .cin_now  (carry_in)
    );

    slice_out_stage u_out (
        .clk     (clk),
        .rst     (rst),
        .phase   (ph_in),
        .res     (alu_res),
        .sum_q   (sum_slice),
        .phase_q (ph_out),
        .ovf_q   (ovf)
    );

    // R6: output phase tag is the input phase one edge later
    assert_phase_follow_R6: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_phase == $past(in_phase)));

    // R2: low slices add with no carry in
    assert_low_sum_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(in_phase)) |->
        ({1'b0, sum_slice} == (({1'b0, $past(a_slice)} + {1'b0, $past(b_slice)}) & {1'b0, {SLICE_W{1'b1}}})));

    // R3/R4: high slice adds the held carry and reports its carry out as overflow
    assert_high_sum_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_phase)) |->
        ({ovf, sum_slice} == ({1'b0, $past(a_slice)} + {1'b0, $past(b_slice)}
                              + {{SLICE_W{1'b0}}, $past(carry_in)})));
endmodule

// File: tb/sliced_word_adder_bench.sv
module sliced_word_adder_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_phase = 1'b0;
    logic [4:0] a_slice = '0;
    logic [4:0] b_slice = '0;
    logic [4:0] sum_slice;
    logic       out_phase;
    logic       ovf;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    sliced_word_adder u_sliced_word_adder (
        .clk       (clk),
        .rst       (rst),
        .in_phase  (in_phase),
        .a_slice   (a_slice),
        .b_slice   (b_slice),
        .sum_slice (sum_slice),
        .out_phase (out_phase),
        .ovf       (ovf)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drives one word as two slices starting at a falling edge; checks each output slice
    // at the falling edge after the rising edge that captured it. Ends at a falling edge,
    // so the next word follows with no gap (R7).
    task automatic send_word(input logic [9:0] a, input logic [9:0] b);
        logic [10:0] full;
        full = {1'b0, a} + {1'b0, b};
        in_phase = 1'b0; a_slice = a[4:0]; b_slice = b[4:0];
        @(negedge clk);
        chk(sum_slice == full[4:0], "R2 low slice", sum_slice, full[4:0]);
        chk(out_phase == 1'b0, "R6 low phase tag", out_phase, 0);
        chk(ovf == 1'b0, "R4 ovf low", ovf, 0);
        in_phase = 1'b1; a_slice = a[9:5]; b_slice = b[9:5];
        @(negedge clk);
        chk(sum_slice == full[9:5], "R3 high slice", sum_slice, full[9:5]);
        chk(out_phase == 1'b1, "R6 high phase tag", out_phase, 1);
        chk(ovf == full[10], "R4 ovf high", ovf, full[10]);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        in_phase = 1'b1; a_slice = 5'd31; b_slice = 5'd31;
        repeat (3) @(negedge clk);
        chk(sum_slice == 5'd0, "R1 reset sum", sum_slice, 0);
        chk(out_phase == 1'b0, "R1 reset phase", out_phase, 0);
        chk(ovf == 1'b0, "R1 reset ovf", ovf, 0);
        rst = 1'b0;
    endtask

    task automatic t_directed();
        send_word(10'd0, 10'd0);
        send_word(10'd31, 10'd1);     // R3 low carry into high slice
        send_word(10'd512, 10'd511);  // no overflow, 1023
        send_word(10'd512, 10'd512);  // R4 overflow without low carry
    endtask

    task automatic t_carry_leak();
        send_word(10'd1023, 10'd1);   // overflow leaves carry register set
        send_word(10'd3, 10'd4);      // R5 low slice must be plain 7
        send_word(10'd1023, 10'd1023);
        send_word(10'd0, 10'd31);     // R5 no inherited carry
    endtask

    task automatic t_chain_phase();
        // R6/R7: long alternating stream keeps phase tags aligned
        for (int i = 0; i < 8; i++) send_word(10'(i * 97), 10'(1023 - i * 61));
    endtask

    task automatic t_random();
        for (int i = 0; i < 60; i++) send_word(10'($urandom), 10'($urandom));
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_directed();
        t_carry_leak();
        t_chain_phase();
        t_random();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule